// File: doc/BRIEF.md
# M/N Fractional Clock-Enable Generator

This block makes a clock-enable strobe on a single reference clock. Several parent sources reach it as enable strobes on that clock. A register-selected source goes through an integer pre-divider and then an optional M/N accumulator, so the output averages M pulses for every N pre-divided source pulses. Software programs the block through a small synchronous register port with three words: a select/divide word, an M/duty word and a control word.

Two of the stored fields use indirect encodings that the hardware decodes. The divide field holds the divide value minus one. The N field holds the bitwise inverse of (N - M), truncated to the counter width, so the hardware rebuilds N as the inverted field plus M. A hold bit in the control word freezes the whole divider path while software rewrites the fields. Clearing the hold bit restarts the pre-divider and the accumulator from zero.

Top module: `mn_clk_gen`

## Requirements
- R1: After reset all three register words read 0 and clk_en_o is low.
- R2: Writes with reg_we_i store only the defined fields and reads return them combinationally. The fields are: select word at address 0 (N field bits 7:0, divide field bits 11:8, source bits 25:24); M word at address 1 (duty field bits 7:0, M bits 23:16); control word at address 2 (bits 3:0). Undefined bits read 0 and address 3 reads 0.
- R3: The source field picks which bit of src_en_i feeds the divider, and strobes on the other sources have no effect on clk_en_o.
- R4: With divide field value p the pre-divider emits one tick per p+1 selected strobes, so a field value of 0 passes every strobe.
- R5: When the M/N stage is active, N = (~N field + M) mod 256. After k pre-divided ticks counted from a restart, exactly floor(k*M/N) output pulses have occurred.
- R6: The M/N stage is active only when control bit 0 (enable) is 1 and the mode field in control bits 2:1 is nonzero (2 is the dual-edge value). Otherwise each pre-divider tick becomes one output pulse.
- R7: If the decoded N is 0, the M/N stage is bypassed and only the pre-divider applies.
- R8: If M >= N while the stage is active, every pre-divider tick produces an output pulse.
- R9: While control bit 3 (hold) is 1, clk_en_o stays low and the pre-divider and accumulator are cleared, so counting restarts at zero when the bit clears.
- R10: A pulse appears on clk_en_o one cycle after the clock edge that samples the strobe completing it, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_en_i | input | NUM_SRC | Parent source enable strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| clk_en_o | output | 1 | Generated clock-enable strobe |

## Verification
The main function is driven with a continuous strobe on the chosen source and several settings: plain pass-through, an integer divide of four, the ratios 3/8 and 1/3 with and without pre-division, and the degenerate cases N = 0 and M = N. Each test counts output pulses and compares the count with floor(ticks*M/N). A wrong N decode, a wrong divide offset or a slipped accumulator shows up as a different count. Tests that strobe an unselected source, or set a nonzero ratio with mode 0, separate source selection and the mode gate from the arithmetic. A single isolated strobe pins the output latency and the pulse width.

// File: rtl/mn_clk_pkg.sv
`timescale 1ns/1ps
package mn_clk_pkg;
  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_MD   = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_HOLD_BIT = 3;
  localparam int CTRL_W        = 4;
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_DUAL = 2'd2;
endpackage

// File: rtl/mn_src_mux.sv
`timescale 1ns/1ps
module mn_src_mux #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               strobe_o
);
  always_comb begin
    strobe_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) strobe_o = src_en_i[i];
    end
  end
endmodule

// File: rtl/mn_prediv.sv
`timescale 1ns/1ps
module mn_prediv #(
  parameter int PD_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            strobe_i,
  input  logic [PD_W-1:0] div_field_i,
  output logic            tick_o
);
  logic [PD_W-1:0] cnt_q;

  // >= so a lowered divide value wraps cleanly
  assign tick_o = strobe_i && !hold_i && (cnt_q >= div_field_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (hold_i)   cnt_q <= '0;
    else if (strobe_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R4
  tick_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

  // R9
  hold_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
endmodule

// File: rtl/mn_accum.sv
`timescale 1ns/1ps
module mn_accum #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  output logic         fire_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic         m_ge_n;

  assign sum    = {1'b0, acc_q} + {1'b0, m_i};
  assign m_ge_n = (m_i >= n_i);
  assign fire_o = tick_i && (m_ge_n || (sum >= {1'b0, n_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (hold_i)  acc_q <= '0;
    else if (tick_i) begin
      if (m_ge_n)      acc_q <= '0;
      else if (fire_o) acc_q <= W'(sum - {1'b0, n_i});
      else             acc_q <= sum[W-1:0];
    end
  end

  // R5: residue stays below N while programming is stable
  acc_below_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || hold_i)
    $stable(m_i) && $stable(n_i) && !$past(hold_i) |-> (acc_q == '0) || (acc_q < n_i));

  // R8
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && m_ge_n) |-> fire_o);
endmodule

// File: rtl/mn_clk_gen.sv
`timescale 1ns/1ps
module mn_clk_gen
  import mn_clk_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int W         = 8,
  parameter int PD_W      = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_SHIFT = 24,
  parameter int M_SHIFT   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               clk_en_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [DATA_W-1:0] W_ONES   = DATA_W'((1 << W) - 1);
  localparam logic [DATA_W-1:0] SEL_MASK = W_ONES
                                         | (DATA_W'((1 << PD_W) - 1) << W)
                                         | (DATA_W'((1 << SEL_W) - 1) << SRC_SHIFT);
  localparam logic [DATA_W-1:0] MD_MASK  = W_ONES | (W_ONES << M_SHIFT);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_W) - 1);

  logic [DATA_W-1:0] sel_q, md_q, ctrl_q;
  logic [W-1:0]      n_field, m_val, n_dec;
  logic [PD_W-1:0]   div_field;
  logic [SEL_W-1:0]  src_sel;
  logic [1:0]        mode;
  logic              hold, mn_active, sel_strobe, pd_tick, mn_fire, clk_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      md_q   <= '0;
      ctrl_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_SEL:  sel_q  <= reg_wdata_i & SEL_MASK;
        ADDR_MD:   md_q   <= reg_wdata_i & MD_MASK;
        ADDR_CTRL: ctrl_q <= reg_wdata_i & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_SEL:  reg_rdata_o = sel_q;
      ADDR_MD:   reg_rdata_o = md_q;
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign n_field   = sel_q[W-1:0];
  assign div_field = sel_q[W +: PD_W];
  assign src_sel   = sel_q[SRC_SHIFT +: SEL_W];
  assign m_val     = md_q[M_SHIFT +: W];
  assign n_dec     = ~n_field + m_val;
  assign mode      = ctrl_q[CTRL_MODE_LSB +: 2];
  assign hold      = ctrl_q[CTRL_HOLD_BIT];
  assign mn_active = ctrl_q[CTRL_EN_BIT] && (mode != MODE_OFF) && (n_dec != '0);

  mn_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_en_i (src_en_i),
    .sel_i    (src_sel),
    .strobe_o (sel_strobe)
  );

  mn_prediv #(.PD_W(PD_W)) u_prediv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold),
    .strobe_i    (sel_strobe),
    .div_field_i (div_field),
    .tick_o      (pd_tick)
  );

  mn_accum #(.W(W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_i (pd_tick),
    .m_i    (m_val),
    .n_i    (n_dec),
    .fire_o (mn_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_en_q <= 1'b0;
    else         clk_en_q <= mn_active ? mn_fire : pd_tick;
  end
  assign clk_en_o = clk_en_q;

  // R9
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> !clk_en_o);

  // R3
  no_strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_strobe |=> !clk_en_o);

  // R6
  bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mn_active && pd_tick) |=> clk_en_o);

  // R10
  one_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !(mn_active ? mn_fire : pd_tick)) |=> !clk_en_o);
endmodule

// File: tb/mn_clk_gen_test.sv
`timescale 1ns/1ps
module mn_clk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_en = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mn_clk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_en_o(clk_en)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // hold, program, release
  task automatic cfg(input int src, input int pdiv, input int m, input int n,
                     input bit en, input int mode);
    logic [7:0] nf;
    nf = ~8'(n - m);
    wr(2'd2, 32'h8);
    wr(2'd0, (32'(src) << 24) | (32'(pdiv) << 8) | 32'(nf));
    wr(2'd1, 32'(m) << 16);
    wr(2'd2, (32'(mode) << 1) | 32'(en));
  endtask

  task automatic run(input logic [3:0] mask, input int t, output int cnt);
    cnt = 0;
    for (int i = 0; i < t; i++) begin
      @(negedge clk); cnt += int'(clk_en); src_en = mask;
    end
    @(negedge clk); cnt += int'(clk_en); src_en = '0;
    @(negedge clk); cnt += int'(clk_en);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d); check("R1 reg reset", d, 0);
    end
    check("R1 clk_en reset", clk_en, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R2 sel word", d, 32'h0300_0FFF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R2 md word", d, 32'h00FF_00FF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R2 ctrl word", d, 32'hF);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check("R2 addr3", d, 0);
    wr(2'd2, 32'h8);
  endtask

  task automatic t_ratio(input string req, input int pdiv, input int m, input int n,
                         input bit en, input int mode, input int t, input int exp);
    int c;
    cfg(0, pdiv, m, n, en, mode);
    run(4'b0001, t, c);
    check(req, c, exp);
  endtask

  task automatic t_source();
    int c;
    cfg(2, 0, 0, 0, 1'b0, 0);
    run(4'b1011, 20, c); check("R3 unselected sources", c, 0);
    run(4'b0100, 20, c); check("R3 selected source", c, 20);
  endtask

  task automatic t_hold();
    int c;
    cfg(0, 0, 0, 0, 1'b0, 0);
    wr(2'd2, 32'h8);
    run(4'b0001, 16, c); check("R9 hold quiet", c, 0);
    // restart from zero: divide by 3 after partial counts
    cfg(0, 2, 3, 8, 1'b1, 2);
    run(4'b0001, 2, c);
    wr(2'd2, 32'h8); wr(2'd2, 32'h5);
    run(4'b0001, 48, c); check("R9 restart count", c, 6);
  endtask

  task automatic t_latency();
    int hi1, hi2, hi0;
    cfg(0, 0, 0, 0, 1'b0, 0);
    @(negedge clk); hi0 = int'(clk_en); src_en = 4'b0001;
    @(negedge clk); src_en = '0; hi1 = int'(clk_en);
    @(negedge clk); hi2 = int'(clk_en);
    check("R10 before", hi0, 0);
    check("R10 next cycle", hi1, 1);
    check("R10 one wide", hi2, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_ratio("R4 pass through",  0, 0, 0, 1'b0, 0, 20, 20);
    t_ratio("R4 divide by 4",   3, 0, 0, 1'b0, 0, 40, 10);
    t_ratio("R5 ratio 3/8",     0, 3, 8, 1'b1, 2, 64, 24);
    t_ratio("R5 ratio 1/3 div2",1, 1, 3, 1'b1, 2, 60, 10);
    t_ratio("R5 ratio 5/7",     0, 5, 7, 1'b1, 1, 30, 21);
    t_ratio("R6 mode zero",     0, 3, 8, 1'b1, 0, 16, 16);
    t_ratio("R6 enable clear",  0, 3, 8, 1'b0, 2, 16, 16);
    t_ratio("R7 N zero",        1, 0, 0, 1'b1, 2, 20, 10);
    t_ratio("R8 M equals N",    0, 5, 5, 1'b1, 2, 10, 10);
    t_source();
    t_hold();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule